// File: doc/BRIEF.md
# Segment Pattern Converter Engine

This engine turns a run of packed 4-bit characters into display data for multiplexed LED digit panels. It reads the characters from a source word memory and writes the results into a destination register array that it owns. The caller starts an operation with a one-cycle strobe. The strobe carries a character start pointer, a length, a destination pointer, a mode and three control inputs: enable, force-dark and force-lit. Two modes convert characters. Mode 2 produces one 8-bit segment image per character. Mode 3 stores each character as a 4-bit digit code and blanks the leading zeros of the number.

The engine handles one character per clock. The number is walked from its last (most significant) character down to its first, so leading-zero suppression needs only one pass. Each write updates a single byte or nibble lane of a destination word and leaves the other lanes of that word unchanged. A one-cycle done pulse ends every accepted strobe. An error flag rejects modes 0 and 1 and any range that runs past the end of the source or the destination.

Top module: `dpc_engine`

## Requirements
- R1: After reset, busy_o, done_o and err_o are 0 and every destination word reads 0.
- R2: In mode 2, each character becomes an 8-bit image, with bit 0 = segment a through bit 6 = segment g and bit 7 (point) = 0. The images for codes 0..F are 3F,06,5B,4F,66,6D,7D,27,7F,6F,40,79,76,58,78,00 (hex). Destination unit k is byte k%2 of word k/2, and byte 0 is bits 7:0.
- R3: Source character k is nibble k%4 of source word k/4, and nibble 0 is bits 3:0. The operation covers characters src_ptr .. src_ptr+len-1, which go to destination units dst_ptr .. dst_ptr+len-1 in the same order.
- R4: In mode 3, each character is copied unchanged into destination unit k, which is nibble k%4 of word k/4.
- R5: In mode 3 conversion, every character above the highest nonzero character of the range is written as blank code F. If the whole range is zero, only the first character shows 0.
- R6: When all_on_i is 1, the range is filled with the lit pattern whatever en_i and all_off_i are. The lit pattern is FF in mode 2 and code 8 in mode 3.
- R7: When all_off_i is 1 and all_on_i is 0, the range is filled with the dark pattern whatever en_i is. The dark pattern is 00 in mode 2 and code F in mode 3.
- R8: When en_i, all_on_i and all_off_i are all 0, the strobe writes nothing and pulses done_o with err_o at 0.
- R9: Destination lanes outside the range keep their contents, including the other lanes of a word that is partly written.
- R10: A strobe with mode 0 or 1, len 0, len above 64, src_ptr+len above 64 or dst_ptr+len above 64 writes nothing. It raises err_o together with done_o for one cycle, one cycle after the strobe.
- R11: An accepted writing strobe keeps busy_o high for len cycles. done_o pulses for one cycle len+1 cycles after the strobe, and the last write is visible by then.
- R12: A strobe that arrives while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation strobe |
| mode_i | input | 2 | Operation mode (2: segment image, 3: digit code) |
| src_ptr_i | input | 6 | First source character |
| len_i | input | 7 | Number of characters, 1..64 |
| dst_ptr_i | input | 6 | First destination unit |
| en_i | input | 1 | Conversion enable |
| all_off_i | input | 1 | Force dark pattern |
| all_on_i | input | 1 | Force lit pattern (wins over all_off_i) |
| src_addr_o | output | 4 | Source word address |
| src_data_i | input | 16 | Source word, combinational reply to src_addr_o |
| rd_addr_i | input | 5 | Destination word read address |
| rd_data_o | output | 16 | Destination word at rd_addr_i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Rejected strobe, valid with done_o |

## Verification
The bench builds the engine with its default parameters: 16-bit words and 64 characters. That gives 16 source words, 32 destination words, 6-bit pointers and a 7-bit length. With these values the full-range case (length 64), the last-character case (pointer 63) and the overflow by one of each pointer sum are all reachable with short runs. Both lanes of a mode 2 destination word and all four lanes of a mode 3 word are exercised. A shadow copy of the whole destination array is compared after each operation, so a stray write to any lane is caught.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    OP_CONV = 2'd0,
    OP_ON   = 2'd1,
    OP_OFF  = 2'd2
  } op_e;

  localparam logic [1:0] MODE_SEG8 = 2'd2;
  localparam logic [1:0] MODE_CODE = 2'd3;
  localparam logic [3:0] BLANK_CODE = 4'hF;
  localparam logic [3:0] FULL_CODE  = 4'h8;

  // bit0 = a ... bit6 = g, bit7 = point
  function automatic logic [7:0] seg_font(input logic [3:0] n);
    logic [7:0] s;
    case (n)
      4'h0: s = 8'h3F;
      4'h1: s = 8'h06;
      4'h2: s = 8'h5B;
      4'h3: s = 8'h4F;
      4'h4: s = 8'h66;
      4'h5: s = 8'h6D;
      4'h6: s = 8'h7D;
      4'h7: s = 8'h27;
      4'h8: s = 8'h7F;
      4'h9: s = 8'h6F;
      4'hA: s = 8'h40;
      4'hB: s = 8'h79;
      4'hC: s = 8'h76;
      4'hD: s = 8'h58;
      4'hE: s = 8'h78;
      default: s = 8'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
#(
  parameter int unsigned MAX_CHARS = 64,
  localparam int unsigned PTR_W = $clog2(MAX_CHARS),
  localparam int unsigned LEN_W = $clog2(MAX_CHARS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [PTR_W-1:0] src_ptr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [PTR_W-1:0] dst_ptr_i,
  input  logic             en_i,
  input  logic             all_off_i,
  input  logic             all_on_i,
  input  logic             nz_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             we_o,
  output logic             suppress_o,
  output logic [PTR_W-1:0] idx_o,
  output logic [PTR_W-1:0] src_ptr_o,
  output logic [PTR_W-1:0] dst_ptr_o,
  output logic [1:0]       mode_o,
  output op_e              op_o
);

  logic             busy_q, done_q, err_q, seen_q;
  logic [PTR_W-1:0] idx_q, src_q, dst_q;
  logic [1:0]       mode_q;
  op_e              op_q, op_d;
  logic [LEN_W:0]   s_end, d_end;
  logic             bad, idle_nop, accept;

  always_comb begin
    s_end = {1'b0, LEN_W'(src_ptr_i)} + {1'b0, len_i};
    d_end = {1'b0, LEN_W'(dst_ptr_i)} + {1'b0, len_i};
    bad   = !mode_i[1] || (len_i == '0) || (len_i > LEN_W'(MAX_CHARS))
         || (s_end > (LEN_W+1)'(MAX_CHARS)) || (d_end > (LEN_W+1)'(MAX_CHARS));
    idle_nop = !en_i && !all_on_i && !all_off_i;
    accept   = start_i && !busy_q;
    if (all_on_i)       op_d = OP_ON;
    else if (all_off_i) op_d = OP_OFF;
    else                op_d = OP_CONV;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      seen_q <= 1'b0;
      idx_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      mode_q <= '0;
      op_q   <= OP_CONV;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (bad) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else if (idle_nop) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          idx_q  <= PTR_W'(len_i - LEN_W'(1));
          src_q  <= src_ptr_i;
          dst_q  <= dst_ptr_i;
          mode_q <= mode_i;
          op_q   <= op_d;
          seen_q <= 1'b0;
        end
      end else if (busy_q) begin
        if (nz_i) seen_q <= 1'b1;
        if (idx_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q - PTR_W'(1);
        end
      end
    end
  end

  // walk runs from the most significant character down, so a zero is
  // leading exactly when no nonzero character has been met yet
  assign suppress_o = (op_q == OP_CONV) && (mode_q == MODE_CODE) && !seen_q
                   && !nz_i && (idx_q != '0);
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign we_o      = busy_q;
  assign idx_o     = idx_q;
  assign src_ptr_o = src_q;
  assign dst_ptr_o = dst_q;
  assign mode_o    = mode_q;
  assign op_o      = op_q;

endmodule

// File: rtl/dpc_pattern.sv
module dpc_pattern
  import dpc_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned MAX_CHARS = 64,
  localparam int unsigned PTR_W  = $clog2(MAX_CHARS),
  localparam int unsigned NSEL_W = $clog2(WORD_W / 4),
  localparam int unsigned SRC_AW = PTR_W - NSEL_W
) (
  input  logic [PTR_W-1:0]  src_ptr_i,
  input  logic [PTR_W-1:0]  idx_i,
  input  logic [1:0]        mode_i,
  input  op_e               op_i,
  input  logic              suppress_i,
  output logic [SRC_AW-1:0] src_addr_o,
  input  logic [WORD_W-1:0] src_data_i,
  output logic              nz_o,
  output logic [7:0]        pat_o
);

  logic [PTR_W-1:0]  cidx;
  logic [NSEL_W-1:0] sel;
  logic [3:0]        nib;
  logic              code_mode;

  assign cidx       = src_ptr_i + idx_i;
  assign sel        = cidx[NSEL_W-1:0];
  assign src_addr_o = cidx[PTR_W-1:NSEL_W];
  assign nib        = src_data_i[{sel, 2'b00} +: 4];
  assign nz_o       = (nib != 4'h0);
  assign code_mode  = (mode_i == MODE_CODE);

  always_comb begin
    unique case (op_i)
      OP_ON:   pat_o = code_mode ? {4'h0, FULL_CODE} : 8'hFF;
      OP_OFF:  pat_o = code_mode ? {4'h0, BLANK_CODE} : 8'h00;
      default: pat_o = code_mode ? {4'h0, (suppress_i ? BLANK_CODE : nib)}
                                 : seg_font(nib);
    endcase
  end

endmodule

// File: rtl/dpc_dst_array.sv
module dpc_dst_array
  import dpc_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned MAX_CHARS = 64,
  localparam int unsigned PTR_W  = $clog2(MAX_CHARS),
  localparam int unsigned DEPTH  = MAX_CHARS / (WORD_W / 8),
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned NSEL_W = $clog2(WORD_W / 4),
  localparam int unsigned BSEL_W = $clog2(WORD_W / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        mode_i,
  input  logic [PTR_W-1:0]  unit_i,
  input  logic [7:0]        pat_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);

  logic [AW-1:0]     wr_addr;
  logic [WORD_W-1:0] wr_mask, wr_data;
  logic [DEPTH-1:0][WORD_W-1:0] words;

  always_comb begin
    if (mode_i == MODE_CODE) begin
      wr_addr = AW'(unit_i >> NSEL_W);
      wr_mask = WORD_W'(4'hF) << {unit_i[NSEL_W-1:0], 2'b00};
      wr_data = WORD_W'(pat_i[3:0]) << {unit_i[NSEL_W-1:0], 2'b00};
    end else begin
      wr_addr = AW'(unit_i >> BSEL_W);
      wr_mask = WORD_W'(8'hFF) << {unit_i[BSEL_W-1:0], 3'b000};
      wr_data = WORD_W'(pat_i) << {unit_i[BSEL_W-1:0], 3'b000};
    end
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  word_q <= '0;
      else if (we_i && (wr_addr == AW'(w)))         word_q <= (word_q & ~wr_mask) | (wr_data & wr_mask);
    end
    assign words[w] = word_q;
  end

  assign rd_data_o = words[rd_addr_i];

endmodule

// File: rtl/dpc_engine.sv
module dpc_engine
  import dpc_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned MAX_CHARS = 64,
  localparam int unsigned PTR_W  = $clog2(MAX_CHARS),
  localparam int unsigned LEN_W  = $clog2(MAX_CHARS + 1),
  localparam int unsigned SRC_AW = PTR_W - $clog2(WORD_W / 4),
  localparam int unsigned DST_AW = $clog2(MAX_CHARS / (WORD_W / 8))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [PTR_W-1:0]  src_ptr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [PTR_W-1:0]  dst_ptr_i,
  input  logic              en_i,
  input  logic              all_off_i,
  input  logic              all_on_i,
  output logic [SRC_AW-1:0] src_addr_o,
  input  logic [WORD_W-1:0] src_data_i,
  input  logic [DST_AW-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  logic             dst_we, suppress, nz;
  logic [PTR_W-1:0] idx, src_base, dst_base, dst_unit;
  logic [1:0]       run_mode;
  op_e              run_op;
  logic [7:0]       pat;

  dpc_ctrl #(.MAX_CHARS(MAX_CHARS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .src_ptr_i  (src_ptr_i),
    .len_i      (len_i),
    .dst_ptr_i  (dst_ptr_i),
    .en_i       (en_i),
    .all_off_i  (all_off_i),
    .all_on_i   (all_on_i),
    .nz_i       (nz),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .we_o       (dst_we),
    .suppress_o (suppress),
    .idx_o      (idx),
    .src_ptr_o  (src_base),
    .dst_ptr_o  (dst_base),
    .mode_o     (run_mode),
    .op_o       (run_op)
  );

  dpc_pattern #(.WORD_W(WORD_W), .MAX_CHARS(MAX_CHARS)) u_pat (
    .src_ptr_i  (src_base),
    .idx_i      (idx),
    .mode_i     (run_mode),
    .op_i       (run_op),
    .suppress_i (suppress),
    .src_addr_o (src_addr_o),
    .src_data_i (src_data_i),
    .nz_o       (nz),
    .pat_o      (pat)
  );

  assign dst_unit = dst_base + idx;

  dpc_dst_array #(.WORD_W(WORD_W), .MAX_CHARS(MAX_CHARS)) u_dst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (dst_we),
    .mode_i    (run_mode),
    .unit_i    (dst_unit),
    .pat_i     (pat),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/dpc_engine_chk.sv
module dpc_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic we_i
);

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_end_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_err_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && !busy_o));

  p_write_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> busy_o);

  p_start_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || (done_o && !err_o)));

endmodule

bind dpc_engine dpc_engine_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .we_i    (dst_we)
);

// File: tb/sim_dpc_engine.sv
`timescale 1ns/1ps
module sim_dpc_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [5:0]  sp = '0, dp = '0;
  logic [6:0]  len = '0;
  logic        en = 1'b0, aoff = 1'b0, aon = 1'b0;
  logic [3:0]  src_addr;
  logic [15:0] src_data;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        busy, done, err;

  logic [15:0] src_mem [16];
  logic [15:0] exp_dst [32];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  assign src_data = src_mem[src_addr];

  dpc_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .src_ptr_i(sp), .len_i(len), .dst_ptr_i(dp), .en_i(en),
    .all_off_i(aoff), .all_on_i(aon), .src_addr_o(src_addr),
    .src_data_i(src_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  // vector: mode[23:22] sp[21:16] len[15:9] dp[8:3] en[2] off[1] on[0]
  localparam int NV = 16;
  localparam logic [23:0] VEC [NV] = '{
    {2'd2, 6'd0,  7'd8,  6'd0,  1'b1, 1'b0, 1'b0},
    {2'd2, 6'd3,  7'd5,  6'd9,  1'b1, 1'b0, 1'b0},
    {2'd3, 6'd0,  7'd12, 6'd16, 1'b1, 1'b0, 1'b0},
    {2'd3, 6'd16, 7'd8,  6'd28, 1'b1, 1'b0, 1'b0},
    {2'd3, 6'd24, 7'd4,  6'd40, 1'b1, 1'b0, 1'b0},
    {2'd2, 6'd40, 7'd3,  6'd20, 1'b0, 1'b1, 1'b1},
    {2'd3, 6'd0,  7'd6,  6'd50, 1'b0, 1'b1, 1'b0},
    {2'd3, 6'd0,  7'd4,  6'd60, 1'b1, 1'b0, 1'b1},
    {2'd2, 6'd8,  7'd4,  6'd0,  1'b0, 1'b0, 1'b0},
    {2'd1, 6'd0,  7'd4,  6'd0,  1'b1, 1'b0, 1'b0},
    {2'd2, 6'd60, 7'd5,  6'd0,  1'b1, 1'b0, 1'b0},
    {2'd3, 6'd0,  7'd3,  6'd62, 1'b1, 1'b0, 1'b0},
    {2'd2, 6'd0,  7'd0,  6'd0,  1'b1, 1'b0, 1'b0},
    {2'd2, 6'd63, 7'd1,  6'd63, 1'b1, 1'b0, 1'b0},
    {2'd0, 6'd0,  7'd2,  6'd0,  1'b0, 1'b0, 1'b1},
    {2'd2, 6'd0,  7'd64, 6'd0,  1'b1, 1'b0, 1'b0}
  };

  function automatic logic [7:0] font(input logic [3:0] n);
    logic [7:0] t [16] = '{8'h3F, 8'h06, 8'h5B, 8'h4F, 8'h66, 8'h6D, 8'h7D, 8'h27,
                           8'h7F, 8'h6F, 8'h40, 8'h79, 8'h76, 8'h58, 8'h78, 8'h00};
    return t[n];
  endfunction

  function automatic logic [3:0] src_char(input int k);
    return src_mem[k / 4][(k % 4) * 4 +: 4];
  endfunction

  task automatic put_unit(input int m, input int u, input logic [7:0] v);
    if (m == 3) exp_dst[u / 4][(u % 4) * 4 +: 4] = v[3:0];
    else        exp_dst[u / 2][(u % 2) * 8 +: 8] = v;
  endtask

  // reference from the requirements; returns expected err and latency
  task automatic model(input logic [23:0] v, output bit e_err, output int e_lat);
    int m, s, l, d, hi;
    m = v[23:22]; s = v[21:16]; l = v[15:9]; d = v[8:3];
    e_err = (m < 2) || (l == 0) || (l > 64) || (s + l > 64) || (d + l > 64);
    if (e_err || (!v[2] && !v[1] && !v[0])) begin
      e_lat = 1;
      return;
    end
    e_lat = l + 1;
    hi = 0;
    for (int i = 0; i < l; i++) if (src_char(s + i) != 4'h0) hi = i;
    for (int i = 0; i < l; i++) begin
      if (v[0])      put_unit(m, d + i, (m == 3) ? 8'h08 : 8'hFF);
      else if (v[1]) put_unit(m, d + i, (m == 3) ? 8'h0F : 8'h00);
      else if (m == 3) put_unit(m, d + i, (i > hi) ? 8'h0F : {4'h0, src_char(s + i)});
      else           put_unit(m, d + i, font(src_char(s + i)));
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_dst(input string req);
    int bad_w;
    logic [15:0] bad_a, bad_e;
    bad_w = -1; bad_a = '0; bad_e = '0;
    for (int w = 0; w < 32; w++) begin
      rd_addr = 5'(w);
      #0.1;
      if (rd_data !== exp_dst[w] && bad_w < 0) begin
        bad_w = w; bad_a = rd_data; bad_e = exp_dst[w];
      end
    end
    check(bad_w < 0, req, $sformatf("destination word %0d", bad_w), bad_a, bad_e);
  endtask

  task automatic drive(input logic [23:0] v);
    mode = v[23:22]; sp = v[21:16]; len = v[15:9]; dp = v[8:3];
    en = v[2]; aoff = v[1]; aon = v[0];
  endtask

  task automatic run_vec(input logic [23:0] v);
    bit e_err;
    int e_lat, lat;
    string req;
    model(v, e_err, e_lat);
    if (e_err)                          req = "R10";
    else if (v[0])                      req = "R6";
    else if (v[1])                      req = "R7";
    else if (!v[2])                     req = "R8";
    else if (v[23:22] == 2'd3)          req = "R4 R5 R9";
    else                                req = "R2 R3 R9";
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(lat == e_lat, "R11", $sformatf("latency (%s)", req), lat, e_lat);
    check(err == e_err, req, "err flag", err, e_err);
    check_dst(req);
    @(negedge clk);
    check(!done && !busy, "R11", "done pulse width", done, 0);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) src_mem[k] = 16'(k * 16'h1111 + 16'h0123);
    src_mem[0] = 16'h0000;
    src_mem[1] = 16'h5678;
    src_mem[2] = 16'h9000;
    src_mem[4] = 16'h0034;
    src_mem[5] = 16'h0000;
    src_mem[6] = 16'h0000;
    src_mem[15] = 16'hFEDC;
    for (int w = 0; w < 32; w++) exp_dst[w] = '0;

    // R1: reset state
    #12;
    check(!busy && !done && !err, "R1", "status after reset", {busy, done, err}, 0);
    check_dst("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err, "R1", "status after release", {busy, done, err}, 0);

    for (int n = 0; n < NV; n++) run_vec(VEC[n]);

    // R12: second strobe during a run is dropped
    begin
      bit e_err;
      int e_lat, lat, pulses;
      model({2'd3, 6'd32, 7'd10, 6'd20, 1'b1, 1'b0, 1'b0}, e_err, e_lat);
      @(negedge clk);
      drive({2'd3, 6'd32, 7'd10, 6'd20, 1'b1, 1'b0, 1'b0});
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1; pulses = 0;
      repeat (2) @(negedge clk);
      lat += 2;
      drive({2'd2, 6'd0, 7'd4, 6'd0, 1'b1, 1'b0, 1'b1});
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
      while (!done && lat < 200) begin
        @(negedge clk);
        lat++;
      end
      check(lat == e_lat, "R12", "latency of first run", lat, e_lat);
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (done) pulses++;
      end
      check(pulses == 0, "R12", "extra done pulses", pulses, 0);
      check_dst("R12");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R11 watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule